// File: doc/BRIEF.md
# Crossover-Seeking Link Bring-up Controller

This controller brings one copper Ethernet port from power-on to a known link state with no processor involvement. It reads PHY registers through a simple request/acknowledge port (the serial management framing sits outside the block). It steers a crossover-select pin that chooses straight or crossed wiring. When it finishes, it leaves four status flags: link, 100 Mbit/s, full duplex and pause.

A `start` pulse runs the sequence. The controller first waits for the PHY to report an incoming signal. It then polls basic status at a fixed millisecond spacing and inverts the crossover pin after every failed poll. Once link is up, it decodes the resolved speed and duplex from the PHY's special status register. It then walks the autonegotiation expansion, advertisement and partner-ability registers to decide pause. A `done` pulse marks completion, and `no_link` reports that either of the retry budgets was used up. A millisecond tick comes from an internal prescaler.

States:
- `S_IDLE`: waiting for a start.
- `S_SIG_RD`: signal-detect read.
- `S_LINK_WAIT`: inter-poll gap.
- `S_LINK_RD`: basic status read.
- `S_SPD_RD`: speed/duplex read.
- `S_ANER_RD`: partner-negotiation check.
- `S_ANAR_RD`: own pause advertisement.
- `S_LPAR_RD`: partner pause.
- `S_REPORT`: success.
- `S_NOLINK`: failure.

Transitions:
- `start` goes to `S_SIG_RD` from any state.
- `S_SIG_RD` goes to `S_LINK_WAIT` on signal, and to `S_NOLINK` when the last try fails. Otherwise it repeats.
- `S_LINK_WAIT` goes to `S_LINK_RD` after the gap.
- `S_LINK_RD` goes to `S_SPD_RD` (link and complete), to `S_REPORT` (link, not complete), back to `S_LINK_WAIT` (no link, tries left), or to `S_NOLINK`.
- `S_SPD_RD` goes to `S_ANER_RD` if negotiation-able, else to `S_REPORT`.
- `S_ANER_RD` goes to `S_ANAR_RD` if the partner negotiates, else to `S_REPORT`.
- `S_ANAR_RD` goes to `S_LPAR_RD` if pause is advertised, else to `S_REPORT`.
- `S_LPAR_RD` goes to `S_REPORT`.
- `S_REPORT` and `S_NOLINK` go to `S_IDLE`.

Top module: `mdix_linkup_ctrl`

## Requirements
- R1: After start, the controller reads register 17 up to SIG_TRIES times back to back; bit 1 set means signal present. If no read shows a signal, it ends with `no_link`=1 and `link_up`, `speed_100`, `full_duplex` and `pause_en` all 0, and it reads no other register.
- R2: On signal detect, `xover` is driven 0 before the first link poll. Each link poll reads register 1 and treats bit 2 as link up. The start of each poll is preceded by a gap of LINK_GAP_MS milliseconds, where one millisecond is CLK_PER_MS clocks.
- R3: Every failed link poll inverts `xover` before the next poll. After LINK_TRIES failed polls the result is the no-link outcome of R1.
- R4: With link up and register 1 bit 5 set, register 31 is read. Bits 4:2 of that register give the speed flag for codes 2 and 6, and the duplex flag for codes 5 and 6. Any other code sets neither flag. With bit 5 clear, register 31 is not read and both flags are 0.
- R5: Pause is 1 only when register 1 bit 3, register 6 bit 0, register 4 bit 10 and register 5 bit 10 are all set. The reads of 6, 4 and 5 happen in that order, and each stops at the first clear bit.
- R6: A successful run sets `link_up`=1 and `no_link`=0. All five status outputs take their new values in the same cycle that `done` is high for exactly one cycle. They hold between completions.
- R7: Every read addresses PHY_ADDR (default 6). `rd_req` stays high with a stable `rd_reg` until `rd_ack`.
- R8: A start while a run is in progress restarts from signal detect and yields a single completion.
- R9: After reset, all outputs are 0 and no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or restart the bring-up sequence |
| rd_req | output | 1 | PHY register read request |
| rd_phy | output | 5 | PHY address of the read |
| rd_reg | output | 5 | PHY register number of the read |
| rd_ack | input | 1 | Read completed; `rd_data` valid |
| rd_data | input | 16 | Register value returned |
| xover | output | 1 | Crossover select: 0 straight, 1 crossed |
| done | output | 1 | One-cycle completion pulse |
| no_link | output | 1 | Last run ended without link |
| link_up | output | 1 | Link flag |
| speed_100 | output | 1 | 1 = 100 Mbit/s, 0 = 10 Mbit/s |
| full_duplex | output | 1 | 1 = full duplex |
| pause_en | output | 1 | Pause resolved on both ends |

## Verification
A wrong state shows up at the management port within one or two transactions. A misdirected branch reads a register that should not be touched, or skips one that should be read, so the bench counts reads per register. A retry counter that is off by one changes the number of register 17 or register 1 reads by exactly one. A bad crossover flip shows in the pin value logged at each link poll. A slip in the gap timer moves the spacing between consecutive status polls by at least a clock period.

// File: rtl/mdix_pkg.sv
package mdix_pkg;

    typedef enum logic [3:0] {
        S_IDLE      = 4'd0,
        S_SIG_RD    = 4'd1,
        S_LINK_WAIT = 4'd2,
        S_LINK_RD   = 4'd3,
        S_SPD_RD    = 4'd4,
        S_ANER_RD   = 4'd5,
        S_ANAR_RD   = 4'd6,
        S_LPAR_RD   = 4'd7,
        S_REPORT    = 4'd8,
        S_NOLINK    = 4'd9
    } mdix_state_e;

    // PHY register numbers
    localparam logic [4:0] PREG_BASIC_STAT = 5'd1;
    localparam logic [4:0] PREG_ADVERT     = 5'd4;
    localparam logic [4:0] PREG_PARTNER    = 5'd5;
    localparam logic [4:0] PREG_AN_EXP     = 5'd6;
    localparam logic [4:0] PREG_MODE_STAT  = 5'd17;
    localparam logic [4:0] PREG_SPEC_STAT  = 5'd31;

    // Bit positions
    localparam int B_SIGNAL   = 1;
    localparam int B_LINK     = 2;
    localparam int B_AN_ABLE  = 3;
    localparam int B_AN_DONE  = 5;
    localparam int B_LP_AN    = 0;
    localparam int B_PAUSE    = 10;
    localparam int B_SPD_LO   = 2;

endpackage

// File: rtl/mdix_ms_tick.sv
module mdix_ms_tick #(
    parameter int CLK_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

    logic [CW-1:0] cnt;

    assign tick = !clr && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr || tick) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mdix_speed_decode.sv
module mdix_speed_decode (
    input  logic [2:0] code,
    output logic       is_100,
    output logic       is_full
);
    always_comb begin
        unique case (code)
            3'd1:    begin is_100 = 1'b0; is_full = 1'b0; end
            3'd5:    begin is_100 = 1'b0; is_full = 1'b1; end
            3'd2:    begin is_100 = 1'b1; is_full = 1'b0; end
            3'd6:    begin is_100 = 1'b1; is_full = 1'b1; end
            default: begin is_100 = 1'b0; is_full = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mdix_linkup_ctrl.sv
module mdix_linkup_ctrl
    import mdix_pkg::*;
#(
    parameter int         CLK_PER_MS  = 100000,
    parameter int         LINK_GAP_MS = 300,
    parameter int         SIG_TRIES   = 100,
    parameter int         LINK_TRIES  = 100,
    parameter logic [4:0] PHY_ADDR    = 5'd6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        rd_req,
    output logic [4:0]  rd_phy,
    output logic [4:0]  rd_reg,
    input  logic        rd_ack,
    input  logic [15:0] rd_data,
    output logic        xover,
    output logic        done,
    output logic        no_link,
    output logic        link_up,
    output logic        speed_100,
    output logic        full_duplex,
    output logic        pause_en
);
    localparam int MAX_TRIES = (SIG_TRIES > LINK_TRIES) ? SIG_TRIES : LINK_TRIES;
    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam int GW = $clog2(LINK_GAP_MS + 1);
    localparam logic [TW-1:0] SIG_LAST  = TW'(SIG_TRIES - 1);
    localparam logic [TW-1:0] LINK_LAST = TW'(LINK_TRIES - 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(LINK_GAP_MS - 1);

    mdix_state_e   state, nxt;
    logic [TW-1:0] try_cnt;
    logic [GW-1:0] gap_cnt;
    logic          ms_tick;
    logic          an_able;
    logic          w_spd, w_dup, w_pause;
    logic          dec_100, dec_full;

    mdix_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != S_LINK_WAIT),
        .tick  (ms_tick)
    );

    mdix_speed_decode u_dec (
        .code    (rd_data[B_SPD_LO+2:B_SPD_LO]),
        .is_100  (dec_100),
        .is_full (dec_full)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        if (start) begin
            nxt = S_SIG_RD;
        end else begin
            unique case (state)
                S_IDLE: nxt = S_IDLE;
                S_SIG_RD:
                    if (rd_ack) begin
                        if (rd_data[B_SIGNAL])       nxt = S_LINK_WAIT;
                        else if (try_cnt == SIG_LAST) nxt = S_NOLINK;
                    end
                S_LINK_WAIT:
                    if (ms_tick && gap_cnt == GAP_LAST) nxt = S_LINK_RD;
                S_LINK_RD:
                    if (rd_ack) begin
                        if (rd_data[B_LINK])
                            nxt = rd_data[B_AN_DONE] ? S_SPD_RD : S_REPORT;
                        else if (try_cnt == LINK_LAST)
                            nxt = S_NOLINK;
                        else
                            nxt = S_LINK_WAIT;
                    end
                S_SPD_RD:
                    if (rd_ack) nxt = an_able ? S_ANER_RD : S_REPORT;
                S_ANER_RD:
                    if (rd_ack) nxt = rd_data[B_LP_AN] ? S_ANAR_RD : S_REPORT;
                S_ANAR_RD:
                    if (rd_ack) nxt = rd_data[B_PAUSE] ? S_LPAR_RD : S_REPORT;
                S_LPAR_RD:
                    if (rd_ack) nxt = S_REPORT;
                S_REPORT: nxt = S_IDLE;
                S_NOLINK: nxt = S_IDLE;
                default:  nxt = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Read request decode
    always_comb begin
        rd_phy = PHY_ADDR;
        rd_req = 1'b1;
        unique case (state)
            S_SIG_RD:  rd_reg = PREG_MODE_STAT;
            S_LINK_RD: rd_reg = PREG_BASIC_STAT;
            S_SPD_RD:  rd_reg = PREG_SPEC_STAT;
            S_ANER_RD: rd_reg = PREG_AN_EXP;
            S_ANAR_RD: rd_reg = PREG_ADVERT;
            S_LPAR_RD: rd_reg = PREG_PARTNER;
            default: begin rd_reg = 5'd0; rd_req = 1'b0; end
        endcase
    end

    // Working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            try_cnt <= '0;
            gap_cnt <= '0;
            xover   <= 1'b0;
            an_able <= 1'b0;
            w_spd   <= 1'b0;
            w_dup   <= 1'b0;
            w_pause <= 1'b0;
        end else if (start) begin
            try_cnt <= '0;
            gap_cnt <= '0;
            w_spd   <= 1'b0;
            w_dup   <= 1'b0;
            w_pause <= 1'b0;
        end else begin
            if (state != S_LINK_WAIT) gap_cnt <= '0;
            else if (ms_tick)         gap_cnt <= gap_cnt + 1'b1;
            if (rd_ack) begin
                unique case (state)
                    S_SIG_RD:
                        if (rd_data[B_SIGNAL]) begin
                            try_cnt <= '0;
                            xover   <= 1'b0;
                        end else begin
                            try_cnt <= try_cnt + 1'b1;
                        end
                    S_LINK_RD:
                        if (rd_data[B_LINK]) begin
                            an_able <= rd_data[B_AN_ABLE];
                        end else begin
                            try_cnt <= try_cnt + 1'b1;
                            xover   <= ~xover;
                        end
                    S_SPD_RD: begin
                        w_spd <= dec_100;
                        w_dup <= dec_full;
                    end
                    S_LPAR_RD: w_pause <= rd_data[B_PAUSE];
                    default: ;
                endcase
            end
        end
    end

    // Status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done        <= 1'b0;
            no_link     <= 1'b0;
            link_up     <= 1'b0;
            speed_100   <= 1'b0;
            full_duplex <= 1'b0;
            pause_en    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == S_REPORT) begin
                done        <= 1'b1;
                no_link     <= 1'b0;
                link_up     <= 1'b1;
                speed_100   <= w_spd;
                full_duplex <= w_dup;
                pause_en    <= w_pause;
            end else if (state == S_NOLINK) begin
                done        <= 1'b1;
                no_link     <= 1'b1;
                link_up     <= 1'b0;
                speed_100   <= 1'b0;
                full_duplex <= 1'b0;
                pause_en    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mdix_linkup_ctrl_chk.sv
module mdix_linkup_ctrl_chk #(
    parameter logic [4:0] PHY_ADDR = 5'd6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       rd_req,
    input logic [4:0] rd_phy,
    input logic [4:0] rd_reg,
    input logic       rd_ack,
    input logic       done,
    input logic       no_link,
    input logic       link_up,
    input logic       speed_100,
    input logic       full_duplex,
    input logic       pause_en
);
    a_r7_phy_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_phy == PHY_ADDR);

    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !start) |=> (rd_req && $stable(rd_reg)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || $stable({no_link, link_up, speed_100, full_duplex, pause_en})));

    a_r1_nolink_clear: assert property (@(posedge clk) disable iff (!rst_n)
        no_link |-> !(link_up || speed_100 || full_duplex || pause_en));

    a_r4_speed_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 || full_duplex) |-> link_up);

    a_r5_pause_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        pause_en |-> link_up);
endmodule

bind mdix_linkup_ctrl mdix_linkup_ctrl_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rd_req      (rd_req),
    .rd_phy      (rd_phy),
    .rd_reg      (rd_reg),
    .rd_ack      (rd_ack),
    .done        (done),
    .no_link     (no_link),
    .link_up     (link_up),
    .speed_100   (speed_100),
    .full_duplex (full_duplex),
    .pause_en    (pause_en)
);

// File: tb/mdix_linkup_ctrl_bench.sv
module mdix_linkup_ctrl_bench;
    localparam int CPM = 4;
    localparam int GAP = 3;
    localparam int SIGT = 6;
    localparam int LNKT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rd_req, rd_ack = 1'b0;
    logic [4:0] rd_phy, rd_reg;
    logic [15:0] rd_data = '0;
    logic xover, done, no_link, link_up, speed_100, full_duplex, pause_en;

    always #5 clk = ~clk;

    mdix_linkup_ctrl #(
        .CLK_PER_MS(CPM), .LINK_GAP_MS(GAP), .SIG_TRIES(SIGT),
        .LINK_TRIES(LNKT), .PHY_ADDR(5'd6)
    ) u_mdix_linkup_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_req(rd_req), .rd_phy(rd_phy), .rd_reg(rd_reg),
        .rd_ack(rd_ack), .rd_data(rd_data), .xover(xover),
        .done(done), .no_link(no_link), .link_up(link_up),
        .speed_100(speed_100), .full_duplex(full_duplex), .pause_en(pause_en)
    );

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    // PHY model configuration and logs
    int cfg_sig_at, cfg_link_min;
    logic cfg_want_x, cfg_cmp, cfg_an, cfg_lpan, cfg_adv, cfg_lp;
    logic [2:0] cfg_code;
    int n17, n1, n31, n6, n4, n5, ndone, addr_err;
    logic xv [0:31];
    int t1 [0:31];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(string tag, int act, int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // PHY register model
    initial begin
        int lat;
        logic [15:0] d;
        lat = 0;
        forever begin
            @(negedge clk);
            if (done) ndone++;
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                if (lat == 0) lat = 1;
                else begin
                    lat = 0;
                    if (rd_phy != 5'd6) addr_err++;
                    d = '0;
                    case (rd_reg)
                        5'd17: begin d[1] = (n17 >= cfg_sig_at); n17++; end
                        5'd1: begin
                            d[2] = (xover == cfg_want_x) && (n1 >= cfg_link_min);
                            d[3] = cfg_an;
                            d[5] = cfg_cmp;
                            if (n1 < 32) begin xv[n1] = xover; t1[n1] = cyc; end
                            n1++;
                        end
                        5'd31: begin d[4:2] = cfg_code; n31++; end
                        5'd6:  begin d[0] = cfg_lpan; n6++; end
                        5'd4:  begin d[10] = cfg_adv; n4++; end
                        5'd5:  begin d[10] = cfg_lp; n5++; end
                        default: addr_err++;
                    endcase
                    rd_data = d;
                    rd_ack = 1'b1;
                end
            end else begin
                lat = 0;
            end
        end
    end

    task automatic clear_logs();
        n17 = 0; n1 = 0; n31 = 0; n6 = 0; n4 = 0; n5 = 0; ndone = 0; addr_err = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int t;
        t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        if (!done) begin
            miscompares++;
            $display("FAIL %s actual=timeout expected=done", tag);
        end
    endtask

    task automatic run(string tag);
        clear_logs();
        pulse_start();
        wait_done(tag);
    endtask

    task automatic set_cfg(int sig_at, int link_min, logic want_x, logic cmp,
                           logic an, logic [2:0] code, logic lpan, logic adv, logic lp);
        cfg_sig_at = sig_at; cfg_link_min = link_min; cfg_want_x = want_x;
        cfg_cmp = cmp; cfg_an = an; cfg_code = code;
        cfg_lpan = lpan; cfg_adv = adv; cfg_lp = lp;
    endtask

    task automatic t_reset();
        check_eq("R9 link_up", int'(link_up), 0);
        check_eq("R9 flags", int'({no_link, speed_100, full_duplex, pause_en}), 0);
        check_eq("R9 done/req/xover", int'({done, rd_req, xover}), 0);
    endtask

    task automatic t_full_pause();
        set_cfg(2, 0, 1'b0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1);
        run("R6 full_pause");
        check_eq("R6 link_up", int'(link_up), 1);
        check_eq("R6 no_link", int'(no_link), 0);
        check_eq("R4 speed_100 code6", int'(speed_100), 1);
        check_eq("R4 full_duplex code6", int'(full_duplex), 1);
        check_eq("R5 pause_en all set", int'(pause_en), 1);
        check_eq("R1 signal reads", n17, 3);
        check_eq("R5 partner read", n5, 1);
        check_eq("R7 addr errors", addr_err, 0);
        repeat (3) @(negedge clk);
        check_eq("R6 single done", ndone, 1);
        check_eq("R6 flags hold", int'({link_up, speed_100, full_duplex, pause_en}), 15);
    endtask

    task automatic t_no_signal();
        set_cfg(1000, 0, 1'b0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1);
        run("R1 no_signal");
        check_eq("R1 no_link", int'(no_link), 1);
        check_eq("R1 flags cleared", int'({link_up, speed_100, full_duplex, pause_en}), 0);
        check_eq("R1 signal read count", n17, SIGT);
        check_eq("R1 no status reads", n1, 0);
    endtask

    task automatic t_xover_toggle();
        set_cfg(0, 0, 1'b1, 1'b1, 1'b0, 3'd1, 1'b1, 1'b1, 1'b1);
        run("R3 xover_toggle");
        check_eq("R3 poll count", n1, 2);
        check_eq("R2 first poll straight", int'(xv[0]), 0);
        check_eq("R3 second poll crossed", int'(xv[1]), 1);
        check_eq("R3 final xover", int'(xover), 1);
        check_eq("R2 poll gap min", int'((t1[1] - t1[0]) >= GAP * CPM), 1);
        check_eq("R2 poll gap max", int'((t1[1] - t1[0]) <= GAP * CPM + 6), 1);
        check_eq("R4 code1 flags", int'({speed_100, full_duplex}), 0);
        check_eq("R5 no aner read when not able", n6, 0);
        check_eq("R5 pause off", int'(pause_en), 0);
        check_eq("R6 link", int'(link_up), 1);
    endtask

    task automatic t_no_link();
        set_cfg(0, 99, 1'b0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1);
        run("R3 no_link");
        check_eq("R3 poll count", n1, LNKT);
        for (int i = 0; i < LNKT; i++)
            check_eq($sformatf("R3 xover at poll %0d", i), int'(xv[i]), i % 2);
        check_eq("R3 final xover", int'(xover), LNKT % 2);
        check_eq("R3 no_link", int'(no_link), 1);
        check_eq("R3 link_up", int'(link_up), 0);
        check_eq("R2 later gap", int'((t1[3] - t1[2]) >= GAP * CPM), 1);
    endtask

    task automatic t_codes();
        set_cfg(0, 0, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 1'b1);
        run("R4 code5");
        check_eq("R4 code5 flags", int'({speed_100, full_duplex}), 1);
        check_eq("R5 partner not negotiating", int'(pause_en), 0);
        check_eq("R5 no advert read", n4, 0);
        set_cfg(0, 0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1, 1'b1, 1'b0);
        run("R4 code2");
        check_eq("R4 code2 flags", int'({speed_100, full_duplex}), 2);
        check_eq("R5 partner no pause", int'(pause_en), 0);
        check_eq("R5 chain order", n6 * 100 + n4 * 10 + n5, 111);
        set_cfg(0, 0, 1'b0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1);
        run("R5 own no pause");
        check_eq("R5 own no pause", int'(pause_en), 0);
        check_eq("R5 no partner read", n5, 0);
        set_cfg(0, 0, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b1, 1'b1);
        run("R4 code3");
        check_eq("R4 code3 flags", int'({speed_100, full_duplex}), 0);
        set_cfg(0, 0, 1'b0, 1'b0, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1);
        run("R4 not complete");
        check_eq("R4 no spec read", n31, 0);
        check_eq("R4 not complete flags", int'({link_up, speed_100, full_duplex, pause_en}), 8);
    endtask

    task automatic t_restart();
        int t;
        set_cfg(0, 99, 1'b0, 1'b1, 1'b0, 3'd6, 1'b1, 1'b1, 1'b1);
        clear_logs();
        pulse_start();
        t = 0;
        while (n1 < 1 && t < 2000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        cfg_link_min = 0;
        n17 = 0;
        pulse_start();
        wait_done("R8 restart");
        check_eq("R8 signal reread", n17, 1);
        check_eq("R8 link after restart", int'(link_up), 1);
        check_eq("R8 flags", int'({speed_100, full_duplex}), 3);
        repeat (3) @(negedge clk);
        check_eq("R8 one completion", ndone, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        summary_and_end();
    end

    initial begin
        clear_logs();
        set_cfg(0, 0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_pause();
        t_no_signal();
        t_xover_toggle();
        t_no_link();
        t_codes();
        t_restart();
        summary_and_end();
    end
endmodule